// File: doc/BRIEF.md
# Dual-Channel Masked Interrupt Aggregator

This block gathers two banks of 32 interrupt request lines, a normal-priority bank and a fast bank, and turns each bank into a single interrupt output for a processor. Every bank samples its source lines into a raw status vector once per clock and holds an enable mask. The output of a bank is asserted while any raw status bit has its enable bit set.

Software never writes an enable mask as a whole. Instead, each bank has a set port that turns on every enable bit written as one, and a clear port that turns off every enable bit written as one. Bits written as zero keep their value, so independent drivers can own different bits without a read-modify-write sequence. Raw and masked status can each be read at their own read-only address. Wrong-direction accesses are reported on an error output.

The register port is a single-cycle access: read data and the error flag are combinational on the request, and a write takes effect at the clock edge that ends the request cycle.

Top module: `int_agg`

## Requirements
- R1: A read at offset 0 of a bank (addr_i[1:0] = 0; addr_i[2] = 0 for the normal bank, 1 for the fast bank) returns that bank's raw status ANDed with its enable mask, with err_o low.
- R2: A read at offset 1 returns the raw status, which is the bank's source lines as sampled at the previous rising clock edge, with err_o low.
- R3: A write at offset 2 ORs wdata_i into the addressed bank's enable mask at the end of the request cycle.
- R4: A write at offset 3 clears every enable bit of the addressed bank whose wdata_i bit is 1, and leaves the other bits as they were.
- R5: The two banks are independent: an access to one bank never changes the other bank's mask, and each bank's raw status follows only its own source lines.
- R6: A write at offset 0 or 1 raises err_o in that cycle and leaves both masks unchanged.
- R7: A read at offset 2 or 3 raises err_o in that cycle and returns the addressed bank's current enable mask.
- R8: irq_o and fiq_o are each the OR of their bank's masked status. They reflect a mask change right after the edge at which the mask changes.
- R9: After reset, both enable masks and both raw status vectors are zero, and both interrupt outputs are low.
- R10: With req_i low, rdata_o is zero and err_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | 32 | Normal bank source lines |
| fiq_src_i | input | 32 | Fast bank source lines |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Bit 2 selects bank, bits 1:0 select register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while req_i is high |
| err_o | output | 1 | Access error for the current request |
| irq_o | output | 1 | Normal bank interrupt |
| fiq_o | output | 1 | Fast bank interrupt |

## Verification
Two events can meet in one cycle: a mask write (set or clear), and a change of the source lines that is captured at the same edge. Both update the masked status and the output together. The bench provokes this with random source patterns that change on every cycle while set and clear writes are issued. It also uses directed cases, such as clearing a bit in the same cycle its source rises and setting a bit in the cycle its source falls. A bench model applies both updates at the edge and judges the interrupt outputs just after it. Status reads made before the next edge are judged against the same model.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
  localparam int unsigned N_CHAN = 2;
  localparam int unsigned CH_W   = $clog2(N_CHAN);
  localparam int unsigned ADDR_W = CH_W + 2;

  typedef enum logic [1:0] {
    REG_MASKED = 2'd0,
    REG_RAW    = 2'd1,
    REG_SET    = 2'd2,
    REG_CLR    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/int_chan.sv
module int_chan #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] mask_o,
  output logic         int_o
);
  logic [W-1:0] raw_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= src_i;
      if (set_i)      mask_q <= mask_q | wdata_i;
      else if (clr_i) mask_q <= mask_q & ~wdata_i;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign int_o  = |(raw_q & mask_q);

  p_raw_sample_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> raw_q == $past(src_i));
  p_set_bits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (mask_q & $past(wdata_i)) == $past(wdata_i));
  p_clr_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (mask_q & $past(wdata_i)) == '0);
  p_mask_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(mask_q));
  p_out_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && |(wdata_i & src_i)) |=> int_o);
  p_out_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (&wdata_i)) |=> !int_o);
endmodule

// File: rtl/int_regif.sv
module int_regif
  import intagg_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [N_CHAN-1:0][W-1:0] raw_i,
  input  logic [N_CHAN-1:0][W-1:0] mask_i,
  output logic [N_CHAN-1:0]        set_o,
  output logic [N_CHAN-1:0]        clr_o,
  output logic [W-1:0]             rdata_o,
  output logic                     err_o
);
  logic [CH_W-1:0] ch;
  reg_sel_e        sel;

  assign ch  = addr_i[ADDR_W-1:2];
  assign sel = reg_sel_e'(addr_i[1:0]);

  always_comb begin
    set_o   = '0;
    clr_o   = '0;
    rdata_o = '0;
    err_o   = 1'b0;
    if (req_i) begin
      unique case (sel)
        REG_MASKED: if (we_i) err_o = 1'b1; else rdata_o = raw_i[ch] & mask_i[ch];
        REG_RAW:    if (we_i) err_o = 1'b1; else rdata_o = raw_i[ch];
        REG_SET:    if (we_i) set_o[ch] = 1'b1;
                    else begin err_o = 1'b1; rdata_o = mask_i[ch]; end
        REG_CLR:    if (we_i) clr_o[ch] = 1'b1;
                    else begin err_o = 1'b1; rdata_o = mask_i[ch]; end
        default:    err_o = 1'b1;
      endcase
    end
  end

  p_err_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> req_i);
  p_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (rdata_o == '0));
  p_one_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({set_o, clr_o}));
  p_err_no_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (set_o == '0 && clr_o == '0));
endmodule

// File: rtl/int_agg.sv
module int_agg
  import intagg_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      irq_src_i,
  input  logic [W-1:0]      fiq_src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic              err_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [N_CHAN-1:0][W-1:0] src, raw, mask;
  logic [N_CHAN-1:0]        set, clr, int_out;

  assign src[0] = irq_src_i;
  assign src[1] = fiq_src_i;

  int_regif #(.W(W)) u_regif (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .raw_i   (raw),
    .mask_i  (mask),
    .set_o   (set),
    .clr_o   (clr),
    .rdata_o (rdata_o),
    .err_o   (err_o)
  );

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    int_chan #(.W(W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src[c]),
      .set_i   (set[c]),
      .clr_i   (clr[c]),
      .wdata_i (wdata_i),
      .raw_o   (raw[c]),
      .mask_o  (mask[c]),
      .int_o   (int_out[c])
    );
  end

  assign irq_o = int_out[0];
  assign fiq_o = int_out[1];

  p_rst_quiet_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (!irq_o && !fiq_o));
endmodule

// File: tb/sim_int_agg.sv
module sim_int_agg;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_src = '0, fiq_src = '0, wdata = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] rdata;
  logic        err, irq, fiq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_raw [2];
  logic [31:0] m_mask[2];

  always #5 clk = ~clk;

  int_agg u0 (
    .clk_i(clk), .rst_ni(rst_ni), .irq_src_i(irq_src), .fiq_src_i(fiq_src),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .err_o(err), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata(input logic rq, input logic w, input logic [2:0] a);
    if (!rq) return '0;
    case (a[1:0])
      2'd0: return w ? 32'd0 : (m_raw[a[2]] & m_mask[a[2]]);
      2'd1: return w ? 32'd0 : m_raw[a[2]];
      default: return w ? 32'd0 : m_mask[a[2]];
    endcase
  endfunction

  function automatic logic exp_err(input logic rq, input logic w, input logic [2:0] a);
    if (!rq) return 1'b0;
    return (a[1] == 1'b0) ? w : !w;
  endfunction

  function automatic string tag_of(input logic rq, input logic w, input logic [2:0] a);
    if (!rq) return "R10";
    if (a[1] == 1'b0) return w ? "R6" : (a[0] ? "R2" : "R1");
    return w ? (a[0] ? "R4" : "R3") : "R7";
  endfunction

  task automatic step(input logic [31:0] si, input logic [31:0] fi, input logic rq,
                      input logic w, input logic [2:0] a, input logic [31:0] d,
                      input string tag = "");
    string t;
    @(negedge clk);
    irq_src = si; fiq_src = fi; req = rq; we = w; addr = a; wdata = d;
    #1;
    t = (tag != "") ? tag : tag_of(rq, w, a);
    if (!(rq && w)) chk({t, " rdata"}, rdata, exp_rdata(rq, w, a));
    chk({t, " err"}, {31'd0, err}, {31'd0, exp_err(rq, w, a)});
    @(posedge clk);
    if (rq && w && a[1:0] == 2'd2) m_mask[a[2]] = m_mask[a[2]] | d;
    if (rq && w && a[1:0] == 2'd3) m_mask[a[2]] = m_mask[a[2]] & ~d;
    m_raw[0] = si;
    m_raw[1] = fi;
    #1;
    chk("R8 irq_o", {31'd0, irq}, {31'd0, |(m_raw[0] & m_mask[0])});
    chk("R8 fiq_o", {31'd0, fiq}, {31'd0, |(m_raw[1] & m_mask[1])});
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_raw[0] = '0; m_raw[1] = '0; m_mask[0] = '0; m_mask[1] = '0;
    irq_src = 32'hffff_ffff; fiq_src = 32'hffff_ffff;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 irq_o in reset", {31'd0, irq}, 32'd0);
    chk("R9 fiq_o in reset", {31'd0, fiq}, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    // masks read back as zero after reset
    step(32'h0, 32'h0, 1'b1, 1'b0, 3'd2, '0, "R9 irq mask");
    step(32'h0, 32'h0, 1'b1, 1'b0, 3'd6, '0, "R9 fiq mask");
    // set and clear on the normal bank
    step(32'h0000_00f0, 32'h0, 1'b1, 1'b1, 3'd2, 32'h0000_0030);
    step(32'h0000_00f0, 32'h0, 1'b1, 1'b0, 3'd0, '0);
    step(32'h0000_00f0, 32'h0, 1'b1, 1'b0, 3'd1, '0);
    step(32'h0000_00f0, 32'h0, 1'b1, 1'b1, 3'd2, 32'h8000_0001);
    step(32'h0000_00f0, 32'h0, 1'b1, 1'b0, 3'd3, '0);
    step(32'h0000_00f0, 32'h0, 1'b1, 1'b1, 3'd3, 32'h0000_0010);
    step(32'h0000_00f0, 32'h0, 1'b1, 1'b0, 3'd2, '0, "R4 mask after clear");
    // the other bank is untouched
    step(32'h0000_00f0, 32'hffff_ffff, 1'b1, 1'b0, 3'd6, '0, "R5 fiq mask");
    step(32'h0000_00f0, 32'hffff_ffff, 1'b1, 1'b0, 3'd5, '0, "R5 fiq raw");
    // status writes flag errors and leave masks alone
    step(32'h0000_00f0, 32'hffff_ffff, 1'b1, 1'b1, 3'd0, 32'hffff_ffff);
    step(32'h0000_00f0, 32'hffff_ffff, 1'b1, 1'b1, 3'd5, 32'hffff_ffff);
    step(32'h0000_00f0, 32'hffff_ffff, 1'b1, 1'b0, 3'd2, '0, "R6 irq mask kept");
    step(32'h0000_00f0, 32'hffff_ffff, 1'b1, 1'b0, 3'd7, '0, "R6 fiq mask kept");
    // clear in the cycle its source rises; set in the cycle its source falls
    step(32'h0000_0000, 32'h0000_0004, 1'b1, 1'b1, 3'd6, 32'h0000_0004);
    step(32'h0000_0000, 32'h0000_0004, 1'b1, 1'b1, 3'd6, 32'h0000_0004, "R8 fiq set");
    step(32'h0000_0000, 32'h0000_0000, 1'b1, 1'b1, 3'd6, 32'h0000_0008, "R8 fiq fall");
    step(32'h0000_0008, 32'h0000_0008, 1'b1, 1'b1, 3'd7, 32'hffff_ffff, "R8 fiq clear all");
    step(32'h0000_0008, 32'h0000_0008, 1'b0, 1'b1, 3'd2, 32'hffff_ffff);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] si, fi, d;
      si = ($urandom_range(3) == 0) ? $urandom() : ($urandom() & $urandom() & $urandom());
      fi = ($urandom_range(3) == 0) ? $urandom() : ($urandom() & $urandom() & $urandom());
      d  = ($urandom_range(7) == 0) ? 32'hffff_ffff : ($urandom() & $urandom());
      step(si, fi, $urandom_range(3) != 0, $urandom_range(1) == 1,
           3'($urandom_range(7)), d);
    end
    @(negedge clk);
    req = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule